// File: doc/BRIEF.md
# Lockstep Comparator Mismatch Self-Test Sequencer

This block proves that a dual-channel lockstep comparator can see a difference on every compared signal. It holds the compare logic under test and a pattern source that feeds it. When started from idle it masks normal comparison through a compare-disable output. It then sends a walking-zero pattern through the comparator, one vector per clock: first across each bit of channel 1 while channel 0 stays all ones, then across each bit of channel 0 while channel 1 stays all ones.

Every vector must produce a mismatch. A match means the comparator is blind at that position. On a match the sequencer stops at once, goes back to idle and raises a sticky error output. A clean pass ends with a single-cycle done pulse. An equality-forcing input lets a bench or a production test confirm that this abort path works.

Cycle numbering below: edge 0 is the rising edge that samples start in idle, and cycle c is the clock period that follows rising edge c.

Top module: `lsc_selftest`

## Requirements
- R1: While synchronous active-low reset is asserted, and in the first cycle after it, busy, done, error and compare-disable are 0 and both pattern buses are all ones. A reset during a run returns the block to idle.
- R2: A start sampled in idle begins a run. Busy and compare-disable are 1 from cycle 0 until the run ends, and the error output is 0 in cycle 0.
- R3: In cycle k, for k from 0 to N-1, channel 0 is all ones and channel 1 is all ones except bit k, which is 0.
- R4: In cycle N+j, for j from 0 to N-1, channel 0 is all ones except bit j, which is 0, and channel 1 is all ones.
- R5: A run with no match applies exactly 2N vectors. Busy stays 1 in cycle 2N. In cycle 2N+1, done is 1 and busy, compare-disable and error are 0. In cycle 2N+2, done is 0.
- R6: The comparator result is registered. If inject_eq_i is high during cycle k, that vector reads as a match. Busy is still 1 in cycle k+1, and in cycle k+2 busy is 0 and error is 1. This includes the last vector, k = 2N-1.
- R7: An aborted run never asserts done.
- R8: Error stays 1 until the next accepted start or a reset.
- R9: A start while busy has no effect: the vectors, their timing and the done cycle are unchanged.
- R10: Whenever the block is idle or in the check cycle after the last vector, both pattern buses are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Run request, sampled in idle |
| inject_eq_i | input | 1 | Forces the comparator to report equality for the current vector |
| cmp_dis_o | output | 1 | Functional comparison disabled while the test owns the comparator |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse on a clean finish |
| err_o | output | 1 | Sticky self-test error |
| ch0_pat_o | output | N | Pattern applied to comparator channel 0 |
| ch1_pat_o | output | N | Pattern applied to comparator channel 1 |

## Verification
Faults inside the block show up quickly at the ports.

- A wrong position counter or phase bit puts the zero on the wrong bit or the wrong bus. The per-cycle pattern check catches it in the very cycle the bad vector is driven.
- A lost or extra step moves the done pulse away from cycle 2N+1.
- A comparator or fault path that ignores the equality result lets an injected match run on to done. A latency error shifts the busy drop away from cycle k+2.
- A faulty error register shows as error cleared at the wrong time, or as error present in cycle 0 of a new run.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Sequencer states: idle, applying vectors, checking the final vector.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_t;

endpackage

// File: rtl/lsc_patgen.sv
// Walking-zero source: the zero sits at bit pos_i of channel 1 while
// phase_i is 0, and of channel 0 while phase_i is 1; all else is one.
module lsc_patgen #(
  parameter int N  = 32,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          apply_i,
  input  logic          phase_i,
  input  logic [PW-1:0] pos_i,
  output logic [N-1:0]  ch0_o,
  output logic [N-1:0]  ch1_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic hit;
    assign hit      = apply_i && (pos_i == PW'(b));
    assign ch0_o[b] = !(hit && phase_i);
    assign ch1_o[b] = !(hit && !phase_i);
  end

endmodule

// File: rtl/lsc_compare.sv
// Comparator under test with a registered result and a valid tag.
module lsc_compare #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ch0_i,
  input  logic [N-1:0] ch1_i,
  input  logic         force_eq_i,
  input  logic         sample_i,
  output logic         eq_q_o,
  output logic         valid_q_o
);

  logic eq_raw;
  assign eq_raw = (ch0_i == ch1_i) || force_eq_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q_o    <= 1'b0;
      valid_q_o <= 1'b0;
    end else begin
      eq_q_o    <= eq_raw;
      valid_q_o <= sample_i;
    end
  end

endmodule

// File: rtl/lsc_ctrl.sv
// Sequencer: steps position and phase, checks each registered result,
// aborts on a match, and pulses done after the last check.
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int N  = 32,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chk_valid_i,
  input  logic          chk_eq_i,
  output logic          apply_o,
  output logic          phase_o,
  output logic [PW-1:0] pos_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          fault_o
);

  seq_state_t    state_q;
  logic [PW-1:0] pos_q;
  logic          phase_q;
  logic          at_top;
  logic          last_vec;

  // Step arithmetic kept in one place.
  function automatic logic is_top(input logic [PW-1:0] p);
    return p == PW'(N - 1);
  endfunction

  function automatic logic [PW-1:0] step_pos(input logic [PW-1:0] p);
    return is_top(p) ? '0 : p + PW'(1);
  endfunction

  assign at_top   = is_top(pos_q);
  assign last_vec = phase_q && at_top;
  assign apply_o  = (state_q == ST_RUN);
  assign busy_o   = (state_q != ST_IDLE);
  assign fault_o  = busy_o && chk_valid_i && chk_eq_i;
  assign phase_o  = phase_q;
  assign pos_o    = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      phase_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            pos_q   <= '0;
            phase_q <= 1'b0;
            err_o   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (fault_o) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b1;
          end else if (last_vec) begin
            state_q <= ST_TAIL;
          end else begin
            pos_q <= step_pos(pos_q);
            if (at_top) phase_q <= 1'b1;
          end
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          if (fault_o) err_o  <= 1'b1;
          else         done_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsc_selftest.sv
// Top: lockstep comparator mismatch self-test.
module lsc_selftest #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         inject_eq_i,
  output logic         cmp_dis_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [N-1:0] ch0_pat_o,
  output logic [N-1:0] ch1_pat_o
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;

  // Internal events, named for the checker.
  logic          apply_w;
  logic          phase_w;
  logic [PW-1:0] pos_w;
  logic          chk_valid_w;
  logic          chk_eq_w;
  logic          fault_w;

  lsc_ctrl #(.N(N)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .chk_valid_i (chk_valid_w),
    .chk_eq_i    (chk_eq_w),
    .apply_o     (apply_w),
    .phase_o     (phase_w),
    .pos_o       (pos_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .fault_o     (fault_w)
  );

  lsc_patgen #(.N(N)) i_patgen (
    .apply_i (apply_w),
    .phase_i (phase_w),
    .pos_i   (pos_w),
    .ch0_o   (ch0_pat_o),
    .ch1_o   (ch1_pat_o)
  );

  lsc_compare #(.N(N)) i_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch0_i      (ch0_pat_o),
    .ch1_i      (ch1_pat_o),
    .force_eq_i (inject_eq_i),
    .sample_i   (apply_w),
    .eq_q_o     (chk_eq_w),
    .valid_q_o  (chk_valid_w)
  );

  assign cmp_dis_o = busy_o;

endmodule

// File: rtl/lsc_selftest_chk.sv
module lsc_selftest_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [N-1:0] ch0_pat_o,
  input logic [N-1:0] ch1_pat_o,
  input logic         apply_i,
  input logic         fault_i
);

  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !err_o));

  // R3
  single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |-> ($countones({ch0_pat_o, ch1_pat_o}) == 2*N - 1));

  // R10
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |-> (&ch0_pat_o && &ch1_pat_o));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R6
  abort_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && fault_i) |=> (!busy_o && err_o));

  // R7
  no_done_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(start_i && !busy_o)) |=> err_o);

endmodule

bind lsc_selftest lsc_selftest_chk #(.N(N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .ch0_pat_o (ch0_pat_o),
  .ch1_pat_o (ch1_pat_o),
  .apply_i   (apply_w),
  .fault_i   (fault_w)
);

// File: tb/test_lsc_selftest.sv
module test_lsc_selftest;

  localparam int N     = 32;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic         inject_eq_i;
  logic         cmp_dis_o;
  logic         busy_o;
  logic         done_o;
  logic         err_o;
  logic [N-1:0] ch0_pat_o;
  logic [N-1:0] ch1_pat_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lsc_selftest #(.N(N)) i_lsc_selftest (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .inject_eq_i (inject_eq_i),
    .cmp_dis_o   (cmp_dis_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .ch0_pat_o   (ch0_pat_o),
    .ch1_pat_o   (ch1_pat_o)
  );

  // Expected patterns for vector k.
  function automatic logic [N-1:0] want_ch0(input int k);
    logic [N-1:0] v = '1;
    if (k >= N) v[k-N] = 1'b0;
    return v;
  endfunction

  function automatic logic [N-1:0] want_ch1(input int k);
    logic [N-1:0] v = '1;
    if (k < N) v[k] = 1'b0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(busy_o == 1'b0 && cmp_dis_o == 1'b0, req, {busy_o, cmp_dis_o}, 0);
    chk(&ch0_pat_o && &ch1_pat_o, req, {ch0_pat_o, ch1_pat_o}, '1);
  endtask

  // One run; inj in [0, 2N-1] forces a match on that vector, else none.
  task automatic run_test(input int inj, input bit noise);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 2*N; k++) begin
      if (k < N)
        chk(ch0_pat_o == want_ch0(k) && ch1_pat_o == want_ch1(k), "R3",
            {ch0_pat_o, ch1_pat_o}, {want_ch0(k), want_ch1(k)});
      else
        chk(ch0_pat_o == want_ch0(k) && ch1_pat_o == want_ch1(k), "R4",
            {ch0_pat_o, ch1_pat_o}, {want_ch0(k), want_ch1(k)});
      chk(busy_o && cmp_dis_o && !done_o, "R2", {busy_o, cmp_dis_o, done_o}, 3'b110);
      if (k == 0) chk(err_o == 1'b0, "R8 cleared by start", err_o, 0);
      inject_eq_i = (k == inj);
      start_i     = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
      inject_eq_i = 1'b0;
      start_i     = 1'b0;
      if (k == inj) begin
        chk(busy_o == 1'b1, "R6 still busy one cycle after match", busy_o, 1);
        @(negedge clk);
        chk(!busy_o && err_o, "R6 abort", {busy_o, err_o}, 2'b01);
        for (int w = 0; w < 3; w++) begin
          chk(done_o == 1'b0, "R7", done_o, 0);
          chk(err_o == 1'b1, "R8 sticky", err_o, 1);
          @(negedge clk);
        end
        return;
      end
    end
    chk(busy_o && !done_o, "R5 check cycle", {busy_o, done_o}, 2'b10);
    chk(&ch0_pat_o && &ch1_pat_o, "R10", {ch0_pat_o, ch1_pat_o}, '1);
    @(negedge clk);
    chk(done_o && !busy_o && !cmp_dis_o && !err_o, "R5 done",
        {done_o, busy_o, cmp_dis_o, err_o}, 4'b1000);
    if (noise) chk(done_o == 1'b1, "R9 timing unchanged", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single pulse", done_o, 0);
    chk_idle("R10");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; inject_eq_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk(!done_o && !err_o, "R1 in reset", {done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    run_test(-1, 1'b0);          // clean run
    run_test(-1, 1'b1);          // R9 start noise while busy
    run_test(0, 1'b0);           // match on first vector
    run_test(2*N-1, 1'b0);       // match on last vector
    run_test(-1, 1'b0);          // new start clears error
    run_test(N, 1'b1);           // match at channel switch
    run_test(N-1, 1'b0);         // match at last channel-1 vector
    for (int r = 0; r < 8; r++) begin
      int pick = $urandom_range(0, 2*N + 4);
      run_test((pick < 2*N) ? pick : -1, 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    // Reset while error is set, then reset in the middle of a run.
    run_test(5, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err_o == 1'b0, "R8 cleared by reset", err_o, 0);
    rst_n = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 mid-run reset");
    chk(!done_o && !err_o, "R1 mid-run reset", {done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_test(-1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule